// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes one memory instruction from a group of 32 lanes. Every lane gives an enable bit and a byte address for a 4-byte access. The block works out which 32-byte aligned segments the enabled lanes touch. It then issues one transaction per segment, lowest address first, on a valid/ready request port. Each transaction carries the segment base address and a mask of the lanes that segment serves.

After the last transaction, the block pulses a completion flag. Two counts are valid at that point. The requested count is the number of distinct 4-byte words multiplied by four. The moved count is the number of segments multiplied by 32. A consumer can divide one by the other to get the bus utilisation of the instruction.

Lane order has no effect on the result. Broadcast, permuted, misaligned, strided and scattered patterns all reduce to the smallest list of segments that covers them. The block takes a new instruction only after the previous one has drained.

Top module: `warp_seg_merger`

## Requirements
- R1: After reset, `in_ready` is 1, `tx_valid` is 0 and `done` is 0. While `in_ready` is 1, `tx_valid` stays 0.
- R2: Every transaction address is a multiple of 32. Bit i of `tx_mask` is set exactly when lane i is enabled and its address, with the low five bits cleared, equals `tx_addr`.
- R3: Within one instruction, transaction addresses strictly increase. Each touched segment is issued exactly once.
- R4: 32 enabled lanes at consecutive 4-byte words starting at a 128-aligned address give 4 transactions, with 128 bytes requested and 128 bytes moved.
- R5: Any permutation of those 32 words across the lanes still gives 4 transactions. Each mask follows the lanes that hold the words of that segment.
- R6: A run of 32 consecutive words gives 5 transactions (160 bytes moved) when it starts off a 32-byte boundary. It gives 4 transactions when it starts on a 32-byte boundary that is not 128-aligned.
- R7: When all lanes name the same word, there is one transaction, 4 bytes requested and 32 bytes moved.
- R8: Scattered addresses that touch N distinct segments give N transactions and N*32 bytes moved. A 12-byte lane stride is handled in this same way: 32 lanes give 12 segments, 128 bytes requested and 384 bytes moved.
- R9: Disabled lanes appear in no mask and add nothing to either count. An instruction with no enabled lanes issues no transaction, and `done` rises on the next cycle with both counts 0.
- R10: `tx_last` is set only on the final transaction of an instruction. `done` pulses for one cycle, in the cycle after that transaction is accepted, with `in_ready` back at 1. `in_ready` is 0 from the cycle after an accept with enabled lanes until then.
- R11: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_addr`, `tx_mask` and `tx_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle, instruction accepted when in_valid is 1 |
| in_active | input | LANES | Per-lane enable |
| in_addr | input | LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| tx_valid | output | 1 | Transaction offered |
| tx_ready | input | 1 | Consumer accepts transaction |
| tx_addr | output | ADDR_W | Segment base address |
| tx_mask | output | LANES | Lanes served by this segment |
| tx_last | output | 1 | Final transaction of the instruction |
| done | output | 1 | One-cycle completion pulse |
| req_bytes | output | 8 | Distinct words times 4, valid from done until next accept |
| moved_bytes | output | 11 | Segments times 32, valid from done until next accept |

## Verification
The segment lists and counts are checked against these address patterns:
- Consecutive aligned words, which tell correct grouping apart from per-lane forwarding.
- A lane permutation of the same words, which exposes any dependence on lane order.
- A run on a 32-byte boundary and a run offset by 4 bytes, which separate the 4-segment and 5-segment cases.
- A broadcast word, which shows requested bytes counted by distinct word rather than by lane.
- A 12-byte stride, wide and clustered scatters, half-enabled lanes with junk addresses on the disabled ones, and an instruction with no lanes enabled.

The whole set is run twice: once with the consumer always ready, and once with random backpressure. The second pass tests hold behaviour and shows that the issue order does not depend on the timing of the consumer.

// File: rtl/warp_seg_pkg.sv
package warp_seg_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_BUSY} merge_state_t;
endpackage

// File: rtl/seg_min_pick.sv
module seg_min_pick #(
  parameter int LANES   = 32,
  parameter int ADDR_W  = 32,
  parameter int SEG_SH  = 5,
  parameter int WORD_SH = 2
) (
  input  logic [LANES-1:0]        pending,
  input  logic [LANES*ADDR_W-1:0] addr_flat,
  output logic [ADDR_W-1:0]       seg_base,
  output logic [LANES-1:0]        seg_mask,
  output logic [(1<<(SEG_SH-WORD_SH))-1:0] word_hits
);
  localparam int KEY_W = ADDR_W - SEG_SH;
  localparam int OFS_W = SEG_SH - WORD_SH;

  logic [KEY_W-1:0] key [LANES];
  logic [OFS_W-1:0] ofs [LANES];

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_split
      assign key[g] = addr_flat[g*ADDR_W+SEG_SH +: KEY_W];
      assign ofs[g] = addr_flat[g*ADDR_W+WORD_SH +: OFS_W];
    end
  endgenerate

  logic [KEY_W-1:0] best;

  always_comb begin
    best = '1;
    for (int l = 0; l < LANES; l++) begin
      if (pending[l] && key[l] < best) best = key[l];
    end
  end

  always_comb begin
    seg_mask  = '0;
    word_hits = '0;
    for (int l = 0; l < LANES; l++) begin
      if (pending[l] && key[l] == best) begin
        seg_mask[l]       = 1'b1;
        word_hits[ofs[l]] = 1'b1;
      end
    end
  end

  assign seg_base = {best, {SEG_SH{1'b0}}};
endmodule

// File: rtl/seg_tally.sv
module seg_tally #(
  parameter int WPS        = 8,
  parameter int SEG_BYTES  = 32,
  parameter int WORD_BYTES = 4,
  parameter int REQ_W      = 8,
  parameter int MOV_W      = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             add,
  input  logic [WPS-1:0]   hits,
  output logic [REQ_W-1:0] req_bytes,
  output logic [MOV_W-1:0] moved_bytes
);
  localparam logic [REQ_W-1:0] WB = REQ_W'(WORD_BYTES);
  localparam logic [MOV_W-1:0] SB = MOV_W'(SEG_BYTES);

  logic [REQ_W-1:0] hit_cnt;

  always_comb begin
    hit_cnt = '0;
    for (int i = 0; i < WPS; i++) hit_cnt = hit_cnt + REQ_W'(hits[i]);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      req_bytes   <= '0;
      moved_bytes <= '0;
    end else if (add) begin
      req_bytes   <= req_bytes + hit_cnt * WB;
      moved_bytes <= moved_bytes + SB;
    end
  end
endmodule

// File: rtl/warp_seg_merger.sv
module warp_seg_merger
  import warp_seg_pkg::*;
#(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int SEG_BYTES  = 32,
  parameter int WORD_BYTES = 4,
  localparam int REQ_W     = $clog2(LANES*WORD_BYTES+1),
  localparam int MOV_W     = $clog2(LANES*SEG_BYTES+1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES-1:0]        in_active,
  input  logic [LANES*ADDR_W-1:0] in_addr,
  output logic                    tx_valid,
  input  logic                    tx_ready,
  output logic [ADDR_W-1:0]       tx_addr,
  output logic [LANES-1:0]        tx_mask,
  output logic                    tx_last,
  output logic                    done,
  output logic [REQ_W-1:0]        req_bytes,
  output logic [MOV_W-1:0]        moved_bytes
);
  localparam int SEG_SH  = $clog2(SEG_BYTES);
  localparam int WORD_SH = $clog2(WORD_BYTES);
  localparam int WPS     = SEG_BYTES / WORD_BYTES;

  merge_state_t            state_q;
  logic [LANES-1:0]        pending_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0]       seg_base;
  logic [LANES-1:0]        seg_mask;
  logic [WPS-1:0]          word_hits;
  logic                    accept, load, finish;

  seg_min_pick #(
    .LANES(LANES), .ADDR_W(ADDR_W), .SEG_SH(SEG_SH), .WORD_SH(WORD_SH)
  ) u_pick (
    .pending(pending_q), .addr_flat(addr_q),
    .seg_base(seg_base), .seg_mask(seg_mask), .word_hits(word_hits)
  );

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign load     = (state_q == ST_BUSY) && (pending_q != '0) && (!tx_valid || tx_ready);
  assign finish   = tx_valid && tx_ready && tx_last;

  seg_tally #(
    .WPS(WPS), .SEG_BYTES(SEG_BYTES), .WORD_BYTES(WORD_BYTES),
    .REQ_W(REQ_W), .MOV_W(MOV_W)
  ) u_tally (
    .clk(clk), .rst(rst), .clear(accept), .add(load), .hits(word_hits),
    .req_bytes(req_bytes), .moved_bytes(moved_bytes)
  );

  always_ff @(posedge clk) begin
    if (accept) addr_q <= in_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      pending_q <= '0;
      tx_valid  <= 1'b0;
      tx_addr   <= '0;
      tx_mask   <= '0;
      tx_last   <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        pending_q <= in_active;
        if (in_active == '0) done <= 1'b1;
        else state_q <= ST_BUSY;
      end
      if (load) begin
        tx_valid  <= 1'b1;
        tx_addr   <= seg_base;
        tx_mask   <= seg_mask;
        tx_last   <= (pending_q & ~seg_mask) == '0;
        pending_q <= pending_q & ~seg_mask;
      end else if (finish) begin
        tx_valid <= 1'b0;
        tx_last  <= 1'b0;
        done     <= 1'b1;
        state_q  <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/warp_seg_merger_chk.sv
module warp_seg_merger_chk #(
  parameter int LANES     = 32,
  parameter int ADDR_W    = 32,
  parameter int SEG_BYTES = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [LANES-1:0]  in_active,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [ADDR_W-1:0] tx_addr,
  input logic [LANES-1:0]  tx_mask,
  input logic              tx_last,
  input logic              done
);
  localparam int SEG_SH = $clog2(SEG_BYTES);

  logic [LANES-1:0]  act_q, served_q;
  logic [ADDR_W-1:0] prev_q;
  logic              have_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q       <= '0;
      served_q    <= '0;
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      act_q       <= in_active;
      served_q    <= '0;
      have_prev_q <= 1'b0;
    end else if (tx_valid && tx_ready) begin
      served_q    <= served_q | tx_mask;
      prev_q      <= tx_addr;
      have_prev_q <= 1'b1;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !tx_valid);

  // R2
  seg_align_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (tx_addr[SEG_SH-1:0] == '0) && (tx_mask != '0));

  // R3
  ascend_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && have_prev_q) |-> (tx_addr > prev_q));

  // R9
  mask_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> ((tx_mask & ~act_q) == '0));

  // R3
  mask_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> ((tx_mask & served_q) == '0));

  // R9
  empty_instr_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_active == '0) |=> done);

  // R10
  done_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && tx_last) |=> (done && in_ready));

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_addr) && $stable(tx_mask) && $stable(tx_last)));
endmodule

bind warp_seg_merger warp_seg_merger_chk #(
  .LANES(LANES), .ADDR_W(ADDR_W), .SEG_BYTES(SEG_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_active(in_active), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_addr(tx_addr), .tx_mask(tx_mask), .tx_last(tx_last), .done(done)
);

// File: tb/sim_warp_seg_merger.sv
module sim_warp_seg_merger;
  localparam int CLK_P = 10;
  localparam int LN    = 32;
  localparam int AW    = 32;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [LN-1:0] m;
    logic          l;
  } txn_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [LN-1:0]  in_active = '0;
  logic [LN*AW-1:0] in_addr = '0;
  logic           tx_valid;
  logic           tx_ready = 1'b1;
  logic [AW-1:0]  tx_addr;
  logic [LN-1:0]  tx_mask;
  logic           tx_last;
  logic           done;
  logic [7:0]     req_bytes;
  logic [10:0]    moved_bytes;

  warp_seg_merger u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_active(in_active), .in_addr(in_addr), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_addr(tx_addr), .tx_mask(tx_mask),
    .tx_last(tx_last), .done(done), .req_bytes(req_bytes),
    .moved_bytes(moved_bytes)
  );

  always #(CLK_P/2) clk = ~clk;

  txn_t  exp_q[$];
  int    exp_n_q[$];
  int    exp_req_q[$];
  string tag_q[$];

  logic [AW-1:0] lane_a [LN];
  logic [LN-1:0] lane_on;

  int n_chk = 0, n_bad = 0, done_seen = 0, tx_seen = 0;
  bit stall_mode = 0;
  bit hold_pend = 0;
  logic [AW-1:0] hold_a;
  logic [LN-1:0] hold_m;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // driver: build the expected segment list, then issue the instruction
  task automatic run_instr(input string tag, input int exp_n, input int exp_req);
    logic [LN-1:0] taken;
    int target;
    int cnt;
    taken = '0;
    cnt   = 0;
    forever begin
      logic [AW-1:0] best;
      bit found;
      txn_t t;
      found = 0;
      best  = '0;
      for (int l = 0; l < LN; l++)
        if (lane_on[l] && !taken[l] && (!found || (lane_a[l] >> 5) < best)) begin
          best  = lane_a[l] >> 5;
          found = 1;
        end
      if (!found) break;
      t.a = best << 5;
      t.m = '0;
      for (int l = 0; l < LN; l++)
        if (lane_on[l] && (lane_a[l] >> 5) == best) t.m[l] = 1'b1;
      taken = taken | t.m;
      t.l = ((lane_on & ~taken) == '0);
      exp_q.push_back(t);
      cnt++;
    end
    check(cnt == exp_n, tag, "model segment count", cnt, exp_n);
    exp_n_q.push_back(exp_n);
    exp_req_q.push_back(exp_req);
    tag_q.push_back(tag);
    target = done_seen + 1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_active = lane_on;
    for (int l = 0; l < LN; l++) in_addr[l*AW +: AW] = lane_a[l];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (lane_on != '0) check(in_ready == 1'b0, "R10", "in_ready while busy", in_ready, 0);
    wait (done_seen == target);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      tx_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
      if (hold_pend) begin
        check(tx_valid && tx_addr == hold_a && tx_mask == hold_m, "R11",
              "held transaction", tx_addr, hold_a);
        hold_pend = 0;
      end
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R3", "unexpected transaction", tx_addr, 0);
        end else begin
          txn_t e;
          e = exp_q.pop_front();
          check(tx_addr == e.a, "R3", "segment address", tx_addr, e.a);
          check(tx_mask == e.m, "R2", "lane mask", tx_mask, e.m);
          check(tx_last == e.l, "R10", "last flag", tx_last, e.l);
        end
        tx_seen++;
      end else if (tx_valid) begin
        hold_pend = 1;
        hold_a    = tx_addr;
        hold_m    = tx_mask;
      end
      if (done) begin
        if (exp_n_q.size() == 0) begin
          check(0, "R10", "unexpected done", 1, 0);
        end else begin
          int en, er;
          string tg;
          en = exp_n_q.pop_front();
          er = exp_req_q.pop_front();
          tg = tag_q.pop_front();
          check(tx_seen == en, tg, "transaction count", tx_seen, en);
          check(int'(req_bytes) == er, tg, "requested bytes", req_bytes, er);
          check(int'(moved_bytes) == en*32, tg, "moved bytes", moved_bytes, en*32);
          check(in_ready == 1'b1, "R10", "in_ready at done", in_ready, 1);
        end
        tx_seen = 0;
        done_seen++;
      end
    end
  end

  task automatic all_patterns();
    // R4 aligned consecutive
    lane_on = '1;
    for (int l = 0; l < LN; l++) lane_a[l] = 32'h1000 + 4*l;
    run_instr("R4", 4, 128);
    // R5 permutation
    for (int l = 0; l < LN; l++) lane_a[l] = 32'h2000 + 4*((l*7) % 32);
    run_instr("R5", 4, 128);
    // R6 run on 32-byte boundary, then offset by one word
    for (int l = 0; l < LN; l++) lane_a[l] = 32'h3020 + 4*l;
    run_instr("R6", 4, 128);
    for (int l = 0; l < LN; l++) lane_a[l] = 32'h3024 + 4*l;
    run_instr("R6", 5, 128);
    // R7 broadcast
    for (int l = 0; l < LN; l++) lane_a[l] = 32'h4444;
    run_instr("R7", 1, 4);
    // R8 stride of 12 bytes
    for (int l = 0; l < LN; l++) lane_a[l] = 32'h5000 + 12*l;
    run_instr("R8", 12, 128);
    // R8 fully scattered, reverse lane order
    for (int l = 0; l < LN; l++) lane_a[l] = 32'h10000 + (31-l)*32'h100;
    run_instr("R8", 32, 128);
    // R8 clustered scatter over 6 segments
    for (int l = 0; l < LN; l++) lane_a[l] = 32'h8000 + (l%6)*32'h240 + (l/6)*4;
    run_instr("R8", 6, 128);
    // R9 half enabled, disabled lanes hold far addresses
    for (int l = 0; l < LN; l++) begin
      lane_on[l] = (l % 2 == 0);
      lane_a[l]  = lane_on[l] ? 32'h6000 + 4*l : 32'hFFFF0000 + 64*l;
    end
    run_instr("R9", 4, 64);
    // R9 no lanes enabled
    lane_on = '0;
    run_instr("R9", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    check(tx_valid == 1'b0, "R1", "tx_valid after reset", tx_valid, 0);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    stall_mode = 0;
    all_patterns();
    stall_mode = 1;
    all_patterns();
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3", "leftover expected transactions", exp_q.size(), 0);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule